// File: doc/BRIEF.md
# Pin Event Flag Unit

This block watches a bank of already-filtered digital pins and, per pin, turns a selected event into a sticky status flag. Each pin has its own 4-bit mode code. One group of codes turns rising, falling or both-edge events into a transfer request for a DMA channel. Another group turns edges, or a held low or high level, into an interrupt. Codes outside both groups leave the pin inert.

All flags together form one status word that is visible on an output bus. The clear path is write-one-to-clear: a write strobe and a data word clear exactly the flags at the positions holding a 1. A flag raised for a DMA request also drops on its own when the per-pin transfer-done input pulses. The port interrupt output is the OR of every flag whose pin is in an interrupt mode.

Pins are sampled on every rising clock edge. An edge is a difference between the current sample and the previous one. A flag changes on the clock edge at which its causing input is sampled.

Top module: `pin_evt_detect`

## Requirements
- R1: Mode code 0x0 and every unlisted code (0x4–0x7, 0xD–0xF) never sets the pin's flag, whatever the pin does.
- R2: Modes 0x1, 0x2 and 0x3 set the flag on a rising, falling or either edge respectively. In these modes dma_req_o[k] equals the flag and the flag does not drive irq_o.
- R3: Modes 0x9, 0xA and 0xB set the flag on a rising, falling or either edge respectively.
- R4: Mode 0x8 sets the flag on every cycle the pin is 0, and mode 0xC on every cycle it is 1. While the level is present, a clear leaves the flag set. Once the level has gone, the flag holds until it is cleared.
- R5: A flag in a DMA mode (0x1–0x3) clears on the edge at which dma_done_i[k] is sampled high.
- R6: A flag in an interrupt mode (0x8–0xC) ignores dma_done_i. It clears only on a write (clr_wr_i high) with a 1 in clr_data_i[k]; a write with 0 at position k leaves it set.
- R7: flag_o shows all flags as one word, bit k for pin k. A write of all ones clears every flag, in any mode, in one cycle.
- R8: irq_o is high exactly when some flag is set whose pin is in a mode from 0x8 to 0xC.
- R9: If an event for pin k is detected on the same edge as a clear of pin k, by write or by transfer-done, the flag ends set.
- R10: Reset clears all flags. No edge is detected on the first clock edge after reset is released, even if a pin is already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Filtered pin levels |
| mode_i | input | 4*NUM_PINS | Mode code, pin k at bits [4k+3:4k] |
| dma_done_i | input | NUM_PINS | Transfer-complete pulse per pin |
| clr_wr_i | input | 1 | Status-word write strobe |
| clr_data_i | input | NUM_PINS | Write-one-to-clear data |
| flag_o | output | NUM_PINS | Status word |
| dma_req_o | output | NUM_PINS | DMA request per pin |
| irq_o | output | 1 | Combined port interrupt |

## Verification
The hardest case to reach is a new event landing on the same edge as a clear for that pin. A flag that was never cleared looks the same as one that was cleared and set again. The bench therefore first raises the flag with one edge. It then applies the opposite edge in either-edge mode together with the write, or, in rising mode, a fresh rising edge together with the transfer-done pulse. It checks that the flag stays set, and then that a lone clear drops it. Level modes get the same treatment: the clear is written while the level is still held, and again after the level has gone.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF      = 4'h0,
    MODE_DMA_RISE = 4'h1,
    MODE_DMA_FALL = 4'h2,
    MODE_DMA_BOTH = 4'h3,
    MODE_IRQ_LOW  = 4'h8,
    MODE_IRQ_RISE = 4'h9,
    MODE_IRQ_FALL = 4'hA,
    MODE_IRQ_BOTH = 4'hB,
    MODE_IRQ_HIGH = 4'hC
  } pin_mode_e;

  typedef struct packed {
    logic on_rise;
    logic on_fall;
    logic on_low;
    logic on_high;
    logic to_dma;
    logic to_irq;
  } det_cfg_t;
endpackage

// File: rtl/pin_mode_dec.sv
module pin_mode_dec
  import pin_evt_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output det_cfg_t          cfg_o
);
  always_comb begin
    cfg_o = '0;
    unique case (mode_i)
      MODE_DMA_RISE: begin cfg_o.on_rise = 1'b1; cfg_o.to_dma = 1'b1; end
      MODE_DMA_FALL: begin cfg_o.on_fall = 1'b1; cfg_o.to_dma = 1'b1; end
      MODE_DMA_BOTH: begin
        cfg_o.on_rise = 1'b1; cfg_o.on_fall = 1'b1; cfg_o.to_dma = 1'b1;
      end
      MODE_IRQ_LOW:  begin cfg_o.on_low  = 1'b1; cfg_o.to_irq = 1'b1; end
      MODE_IRQ_RISE: begin cfg_o.on_rise = 1'b1; cfg_o.to_irq = 1'b1; end
      MODE_IRQ_FALL: begin cfg_o.on_fall = 1'b1; cfg_o.to_irq = 1'b1; end
      MODE_IRQ_BOTH: begin
        cfg_o.on_rise = 1'b1; cfg_o.on_fall = 1'b1; cfg_o.to_irq = 1'b1;
      end
      MODE_IRQ_HIGH: begin cfg_o.on_high = 1'b1; cfg_o.to_irq = 1'b1; end
      default:       cfg_o = '0;  // unlisted codes act as off
    endcase
  end
endmodule

// File: rtl/pin_evt_cell.sv
module pin_evt_cell
  import pin_evt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     armed_i,
  input  logic     pin_i,
  input  det_cfg_t cfg_i,
  input  logic     dma_done_i,
  input  logic     clr_i,
  output logic     flag_o
);
  logic prev_q, flag_q;
  logic rise, fall, det, drop;

  assign rise = armed_i &  pin_i & ~prev_q;
  assign fall = armed_i & ~pin_i &  prev_q;

  assign det  = (cfg_i.on_rise & rise) | (cfg_i.on_fall & fall) |
                (cfg_i.on_low & ~pin_i) | (cfg_i.on_high & pin_i);
  assign drop = clr_i | (cfg_i.to_dma & dma_done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin_i;
      // detection takes precedence over any clear
      if (det)       flag_q <= 1'b1;
      else if (drop) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pin_evt_detect.sv
module pin_evt_detect
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_PINS-1:0]        pin_i,
  input  logic [NUM_PINS*MODE_W-1:0] mode_i,
  input  logic [NUM_PINS-1:0]        dma_done_i,
  input  logic                       clr_wr_i,
  input  logic [NUM_PINS-1:0]        clr_data_i,
  output logic [NUM_PINS-1:0]        flag_o,
  output logic [NUM_PINS-1:0]        dma_req_o,
  output logic                       irq_o
);
  logic                armed_q;
  logic [NUM_PINS-1:0] clr_vec, dma_sel, irq_sel;

  // first edge after reset only captures pin history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assign clr_vec = {NUM_PINS{clr_wr_i}} & clr_data_i;

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    det_cfg_t cfg;

    pin_mode_dec u_dec (
      .mode_i (mode_i[k*MODE_W +: MODE_W]),
      .cfg_o  (cfg)
    );

    pin_evt_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .armed_i    (armed_q),
      .pin_i      (pin_i[k]),
      .cfg_i      (cfg),
      .dma_done_i (dma_done_i[k]),
      .clr_i      (clr_vec[k]),
      .flag_o     (flag_o[k])
    );

    assign dma_sel[k] = cfg.to_dma;
    assign irq_sel[k] = cfg.to_irq;
  end

  assign dma_req_o = flag_o & dma_sel;
  assign irq_o     = |(flag_o & irq_sel);
endmodule

// File: rtl/pin_evt_detect_chk.sv
module pin_evt_detect_chk #(
  parameter int NUM_PINS = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_PINS*4-1:0] mode_i,
  input logic [NUM_PINS-1:0]   dma_done_i,
  input logic                  clr_wr_i,
  input logic [NUM_PINS-1:0]   clr_data_i,
  input logic [NUM_PINS-1:0]   flag_o,
  input logic [NUM_PINS-1:0]   dma_req_o,
  input logic                  irq_o
);
  logic [NUM_PINS-1:0] irq_m, dma_m, off_m, wr_m;

  always_comb begin
    for (int k = 0; k < NUM_PINS; k++) begin
      irq_m[k] = (mode_i[k*4 +: 4] >= 4'h8) && (mode_i[k*4 +: 4] <= 4'hC);
      dma_m[k] = (mode_i[k*4 +: 4] >= 4'h1) && (mode_i[k*4 +: 4] <= 4'h3);
      off_m[k] = !irq_m[k] && !dma_m[k];
    end
  end

  assign wr_m = clr_wr_i ? clr_data_i : '0;

  // R1
  a_r1_off_never_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o & ~$past(flag_o) & $past(off_m)) == '0);

  // R2
  a_r2_req_from_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o & ~flag_o) == '0);

  // R5: DMA flags drop only through done or a write
  a_r5_dma_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flag_o & dma_m & ~dma_done_i & ~wr_m) & ~flag_o) == '0);

  // R6
  a_r6_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flag_o & irq_m & ~wr_m) & ~flag_o) == '0);

  // R8
  a_r8_port_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(flag_o & irq_m));
endmodule

bind pin_evt_detect pin_evt_detect_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .dma_done_i (dma_done_i),
  .clr_wr_i   (clr_wr_i),
  .clr_data_i (clr_data_i),
  .flag_o     (flag_o),
  .dma_req_o  (dma_req_o),
  .irq_o      (irq_o)
);

// File: tb/pin_evt_detect_test.sv
`timescale 1ns/100ps
module pin_evt_detect_test;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pin = '0;
  logic [N*4-1:0] mode = '0;
  logic [N-1:0]  done = '0;
  logic          clr_wr = 1'b0;
  logic [N-1:0]  clr_data = '0;
  logic [N-1:0]  flag, dma_req;
  logic          irq;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pin_evt_detect #(.NUM_PINS(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .mode_i(mode),
    .dma_done_i(done), .clr_wr_i(clr_wr), .clr_data_i(clr_data),
    .flag_o(flag), .dma_req_o(dma_req), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_mode(int p, logic [3:0] m);
    mode[p*4 +: 4] = m;
  endtask

  task automatic wr_clear(logic [N-1:0] d);
    clr_wr = 1'b1; clr_data = d;
    tick();
    clr_wr = 1'b0; clr_data = '0;
  endtask

  task automatic cleanup();
    mode = '0;
    wr_clear('1);
  endtask

  task automatic t_reset();
    chk("R10 flags in reset", flag, 32'h0);
    rst_n = 1'b1;
    tick();
    chk("R10 no edge after release", flag, 32'h0);
    chk("R10 irq after release", {31'b0, irq}, 32'h0);
    pin[3] = 1'b0;
    cleanup();
  endtask

  task automatic t_dma_modes();
    set_mode(0, 4'h1); set_mode(1, 4'h2); set_mode(2, 4'h3);
    pin[2:0] = 3'b111;
    tick();
    chk("R2 rise set", flag, 32'h5);
    chk("R2 dma req", dma_req, 32'h5);
    chk("R8 dma flags no irq", {31'b0, irq}, 32'h0);
    pin[2:0] = 3'b000;
    tick();
    chk("R2 fall set", flag, 32'h7);
    done[1:0] = 2'b11;
    tick();
    done = '0;
    chk("R5 done clears", flag, 32'h4);
    done[2] = 1'b1;
    tick();
    done = '0;
    chk("R5 done clears pin2", flag, 32'h0);
    cleanup();
  endtask

  task automatic t_irq_edges();
    set_mode(4, 4'h9); set_mode(5, 4'hA); set_mode(6, 4'hB);
    pin[6:4] = 3'b111;
    tick();
    chk("R3 rise set", flag, 32'h50);
    chk("R8 irq high", {31'b0, irq}, 32'h1);
    chk("R2 no dma req in irq mode", dma_req, 32'h0);
    pin[6:4] = 3'b000;
    tick();
    chk("R3 fall set", flag, 32'h70);
    wr_clear(32'h10);
    chk("R6 write one clears", flag, 32'h60);
    wr_clear(32'h0);
    chk("R6 write zero holds", flag, 32'h60);
    done[6:5] = 2'b11;
    tick();
    done = '0;
    chk("R6 done ignored", flag, 32'h60);
    cleanup();
  endtask

  task automatic t_level();
    set_mode(8, 4'h8); set_mode(9, 4'hC);
    tick();
    chk("R4 low level set", flag, 32'h100);
    chk("R8 irq level", {31'b0, irq}, 32'h1);
    wr_clear(32'h100);
    chk("R4 clear while low", flag, 32'h100);
    pin[8] = 1'b1;
    tick();
    chk("R4 holds after level gone", flag, 32'h100);
    wr_clear(32'h100);
    chk("R4 clear after level gone", flag, 32'h0);
    pin[9] = 1'b1;
    tick();
    chk("R4 high level set", flag, 32'h200);
    pin[9:8] = 2'b00;
    cleanup();
  endtask

  task automatic t_disabled();
    set_mode(10, 4'h0); set_mode(11, 4'h5); set_mode(12, 4'hF); set_mode(13, 4'hD);
    pin[13:10] = 4'hF;
    tick();
    pin[13:10] = 4'h0;
    tick();
    chk("R1 off modes no flag", flag, 32'h0);
    chk("R1 off modes no irq", {31'b0, irq}, 32'h0);
    chk("R1 off modes no dma", dma_req, 32'h0);
    cleanup();
  endtask

  task automatic t_race();
    set_mode(13, 4'hB); set_mode(14, 4'h1);
    pin[14:13] = 2'b11;
    tick();
    chk("R9 setup", flag, 32'h6000);
    pin[13] = 1'b0; clr_wr = 1'b1; clr_data = 32'h2000;
    tick();
    clr_wr = 1'b0; clr_data = '0;
    chk("R9 edge beats write", flag, 32'h6000);
    pin[14] = 1'b0;
    tick();
    pin[14] = 1'b1; done[14] = 1'b1;
    tick();
    done = '0;
    chk("R9 edge beats done", flag, 32'h6000);
    wr_clear(32'h2000);
    chk("R9 lone clear", flag, 32'h4000);
    pin[14] = 1'b0;
    cleanup();
  endtask

  task automatic t_clear_all();
    set_mode(0, 4'h3); set_mode(4, 4'hB); set_mode(31, 4'h9);
    pin[0] = 1'b1; pin[4] = 1'b1; pin[31] = 1'b1;
    tick();
    chk("R7 word read", flag, 32'h8000_0011);
    wr_clear('1);
    chk("R7 all ones clears", flag, 32'h0);
    chk("R7 irq drops", {31'b0, irq}, 32'h0);
    pin = '0;
    cleanup();
  endtask

  initial begin
    pin[3] = 1'b1;
    set_mode(3, 4'h9);
    repeat (3) tick();
    t_reset();
    t_dma_modes();
    t_irq_edges();
    t_level();
    t_disabled();
    t_race();
    t_clear_all();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule